// File: doc/BRIEF.md
# Power Domain Controller Register Block

This block is a register-mapped controller for a set of power domains. Software asks for a domain to be switched on or off by writing a one to that domain's on-request or off-request word. A built-in model of the power switch then walks the domain through a rising or falling transition state, which lasts a configurable number of clock cycles, and settles it in the on or off state. Only one transition is in flight at a time. A global ready word shows whether the controller can take a new request. A request that arrives while the controller is busy is refused: it sets the domain's error bit, and software may submit it again.

When a transition finishes, the domain's completion flag is set, but only if the domain's interrupt enable bit is set. Flags, enables and masks are held in banks of 32 domains. A flag is cleared by writing a one to its bit. The interrupt line is raised by any flag whose domain is enabled and not masked. A mask bit hides the flag from the line but leaves it readable. Summary banks report which domains are fully on and which are fully off. Reads return data one cycle after the access, with a valid strobe.

Top module: `pdom_regblock`

## Requirements
- R1: After reset every domain reads as off (status word 0x0000_0001), its error word reads 0, the ready word at 0x000 reads 0x3, all flags read 0 and `irq` is low.
- R2: The word at 0x000 reads 0x3 while no domain is in transition and 0x0 during a transition.
- R3: Domain n owns the words at 0x1000 + 0x40·n. Its status is at +0x0, with bit 0 = off, bit 4 = on, bit 8 = falling and bit 12 = rising. Writing a value with bit 0 set to +0x4 (on) or +0x8 (off) while ready is accepted. The status then reads rising or falling for SEQ_DELAY cycles, beginning the cycle after the write, and then reads on or off.
- R4: A request written while a transition is in flight sets bit 0 of the domain's error word at +0xC and leaves its state unchanged. An accepted request clears that bit.
- R5: A write to a request word with bit 0 clear has no effect.
- R6: The words 0x800 + 4·b show the on-state bits and 0x808 + 4·b show the off-state bits. Domain n maps to bank b = n/32, bit n%32.
- R7: When a transition completes, the domain's flag in the bank word at 0x810 + 4·b is set only if its enable bit at 0x820 + 4·b is 1. Writing 1 to a flag bit clears it; writing 0 leaves it set.
- R8: `irq` is the OR over all domains of flag AND enable AND NOT mask, with the mask at 0x830 + 4·b. A set mask bit lowers `irq` but the flag stays readable.
- R9: Reads of unmapped addresses return 0, and writes to them change nothing. Unmapped addresses include banks at or above ceil(NUM_DOM/32), domain blocks at or above NUM_DOM, unused block offsets and unaligned addresses.
- R10: At most one domain is in a rising or falling state at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read |
| bus_rvalid | output | 1 | High for the cycle that carries read data |
| irq | output | 1 | Combined completion interrupt |

## Verification
The case that is hardest to reach from the ports is a refused request. It needs a second request to land inside the SEQ_DELAY window of a transition that is already running. The bench counts cycles exactly from the accepting write. It submits the competing request two cycles into the window and reads the error word, the victim's status and the running domain's status on fixed cycles before and after the settling edge. Bank 1 is reached by using a domain above 31 together with a mask set on bank 0. This shows that the interrupt line follows one bank while a masked flag in the other bank stays set.

// File: rtl/pdom_pkg.sv
package pdom_pkg;

   typedef enum logic [1:0] {
      PD_OFF  = 2'd0,
      PD_UP   = 2'd1,
      PD_ON   = 2'd2,
      PD_DOWN = 2'd3
   } pd_state_e;

   localparam int unsigned CM_BASE    = 32'h0000_0800;
   localparam int unsigned DOM_BASE   = 32'h0000_1000;
   localparam int unsigned DOM_SHIFT  = 6;

   localparam logic [1:0] GRP_SUM = 2'd0;
   localparam logic [1:0] GRP_FLG = 2'd1;
   localparam logic [1:0] GRP_ENA = 2'd2;
   localparam logic [1:0] GRP_MSK = 2'd3;

   localparam logic [3:0] SUB_STAT = 4'd0;
   localparam logic [3:0] SUB_ON   = 4'd1;
   localparam logic [3:0] SUB_OFF  = 4'd2;
   localparam logic [3:0] SUB_ERR  = 4'd3;

   function automatic logic [31:0] pd_status_word(input pd_state_e s);
      logic [31:0] w;
      w = '0;
      case (s)
         PD_OFF:  w[0]  = 1'b1;
         PD_ON:   w[4]  = 1'b1;
         PD_DOWN: w[8]  = 1'b1;
         default: w[12] = 1'b1;
      endcase
      return w;
   endfunction

endpackage

// File: rtl/pdom_timer.sv
module pdom_timer #(
   parameter int DELAY = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);
   localparam int CW = (DELAY > 1) ? $clog2(DELAY) : 1;
   localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

   logic          active_q;
   logic [CW-1:0] cnt_q;

   assign busy = active_q;
   assign done = active_q && (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
      end else if (start) begin
         active_q <= 1'b1;
         cnt_q    <= '0;
      end else if (done) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
      end else if (active_q) begin
         cnt_q    <= cnt_q + 1'b1;
      end
   end

   assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);
   assert_done_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> !busy);

endmodule

// File: rtl/pdom_cell.sv
module pdom_cell
   import pdom_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wr_on,
   input  logic      wr_off,
   input  logic      busy,
   input  logic      done,
   output pd_state_e state,
   output logic      err,
   output logic      accept
);
   logic req;
   assign req    = wr_on | wr_off;
   assign accept = req & ~busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= PD_OFF;
         err   <= 1'b0;
      end else begin
         if (req) err <= busy;
         if (accept) begin
            state <= wr_on ? PD_UP : PD_DOWN;
         end else if (done) begin
            case (state)
               PD_UP:   state <= PD_ON;
               PD_DOWN: state <= PD_OFF;
               default: state <= state;
            endcase
         end
      end
   end

   assert_reject_sets_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req && busy) |=> (err && state == $past(state)));
   assert_accept_clears_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !busy) |=> !err);
   assert_on_enters_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_on && !busy) |=> state == PD_UP);
   assert_no_skip_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PD_OFF) |=> state != PD_ON);
   assert_no_skip_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PD_ON) |=> state != PD_OFF);

endmodule

// File: rtl/pdom_irq.sv
module pdom_irq #(
   parameter int NUM_DOM  = 40,
   parameter int NBANK    = 2,
   parameter bit SET_WINS = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_DOM-1:0] set_vec,
   input  logic [NBANK-1:0]   en_we,
   input  logic [NBANK-1:0]   msk_we,
   input  logic [NBANK-1:0]   clr_we,
   input  logic [31:0]        wdata,
   output logic [NUM_DOM-1:0] flag_q,
   output logic [NUM_DOM-1:0] en_q,
   output logic [NUM_DOM-1:0] msk_q,
   output logic               irq
);
   logic unused_wdata;
   assign unused_wdata = ^wdata;

   for (genvar d = 0; d < NUM_DOM; d++) begin : g_bit
      localparam int BK = d / 32;
      localparam int BT = d % 32;
      logic f_q, e_q, m_q, set_c, clr_c;

      assign set_c = set_vec[d] & e_q;
      assign clr_c = clr_we[BK] & wdata[BT];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            e_q <= 1'b0;
            m_q <= 1'b0;
         end else begin
            if (en_we[BK])  e_q <= wdata[BT];
            if (msk_we[BK]) m_q <= wdata[BT];
         end
      end

      if (SET_WINS) begin : g_setwin
         always_ff @(posedge clk) begin
            if (!rst_n) f_q <= 1'b0;
            else        f_q <= set_c | (f_q & ~clr_c);
         end
      end else begin : g_clrwin
         always_ff @(posedge clk) begin
            if (!rst_n) f_q <= 1'b0;
            else        f_q <= (set_c | f_q) & ~clr_c;
         end
      end

      assign flag_q[d] = f_q;
      assign en_q[d]   = e_q;
      assign msk_q[d]  = m_q;
   end

   assign irq = |(flag_q & en_q & ~msk_q);

   assert_flag_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q & ~$past(flag_q) & ~$past(en_q)) == '0);
   assert_mask_blocks_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ((flag_q & ~msk_q) != '0));

endmodule

// File: rtl/pdom_regblock.sv
module pdom_regblock
   import pdom_pkg::*;
#(
   parameter int NUM_DOM   = 40,
   parameter int SEQ_DELAY = 6,
   parameter int ADDR_W    = 16,
   parameter bit SET_WINS  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              bus_rvalid,
   output logic              irq
);
   localparam int NBANK = (NUM_DOM + 31) / 32;
   localparam int PADW  = NBANK * 32;
   localparam int DIW   = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1;
   localparam int HW    = ADDR_W - DOM_SHIFT;

   if (NUM_DOM < 1 || NUM_DOM > 64) begin : g_bad_dom
      $error("pdom_regblock: NUM_DOM must lie in 1..64");
   end
   if (SEQ_DELAY < 1) begin : g_bad_dly
      $error("pdom_regblock: SEQ_DELAY must be at least 1");
   end
   if (ADDR_W < 13) begin : g_bad_aw
      $error("pdom_regblock: ADDR_W too narrow for the domain area");
   end

   // access decode
   logic          wr_en, rd_en;
   logic          glb_hit, cm_hit, dom_hit, aligned;
   logic [1:0]    grp, wbank;
   logic          sum_bank_ok, wbank_ok;
   logic [HW-1:0] dblk;
   logic [DIW-1:0] dom_sel;
   logic [3:0]    dsub;

   assign wr_en   = bus_sel & bus_wr;
   assign rd_en   = bus_sel & ~bus_wr;
   assign aligned = (bus_addr[1:0] == 2'b00);
   assign glb_hit = (bus_addr == '0);
   assign cm_hit  = aligned && (bus_addr[ADDR_W-1:DOM_SHIFT] == HW'(CM_BASE >> DOM_SHIFT));
   assign grp     = bus_addr[5:4];
   assign wbank   = bus_addr[3:2];
   assign wbank_ok    = (int'(wbank) < NBANK);
   assign sum_bank_ok = (int'(bus_addr[2]) < NBANK);
   assign dblk    = bus_addr[ADDR_W-1:DOM_SHIFT] - HW'(DOM_BASE >> DOM_SHIFT);
   assign dom_hit = aligned && (bus_addr >= ADDR_W'(DOM_BASE)) && (dblk < HW'(NUM_DOM));
   assign dom_sel = dblk[DIW-1:0];
   assign dsub    = bus_addr[5:2];

   // domain cells
   pd_state_e          st [NUM_DOM];
   logic [NUM_DOM-1:0] on_w, off_w, err_v, acc_v, trans_v, on_v, off_v;
   logic               busy, seq_done;

   for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
      assign on_w[d]  = wr_en && dom_hit && (dom_sel == DIW'(d)) &&
                        (dsub == SUB_ON) && bus_wdata[0];
      assign off_w[d] = wr_en && dom_hit && (dom_sel == DIW'(d)) &&
                        (dsub == SUB_OFF) && bus_wdata[0];

      pdom_cell u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_on  (on_w[d]),
         .wr_off (off_w[d]),
         .busy   (busy),
         .done   (seq_done),
         .state  (st[d]),
         .err    (err_v[d]),
         .accept (acc_v[d])
      );

      assign trans_v[d] = (st[d] == PD_UP) || (st[d] == PD_DOWN);
      assign on_v[d]    = (st[d] == PD_ON);
      assign off_v[d]   = (st[d] == PD_OFF);
   end

   pdom_timer #(.DELAY(SEQ_DELAY)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (|acc_v),
      .busy  (busy),
      .done  (seq_done)
   );

   // interrupt banks
   logic [NBANK-1:0]   en_we, msk_we, clr_we;
   logic [NUM_DOM-1:0] flag_q, en_q, msk_q;

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      assign en_we[b]  = wr_en && cm_hit && (grp == GRP_ENA) && (wbank == 2'(b));
      assign msk_we[b] = wr_en && cm_hit && (grp == GRP_MSK) && (wbank == 2'(b));
      assign clr_we[b] = wr_en && cm_hit && (grp == GRP_FLG) && (wbank == 2'(b));
   end

   pdom_irq #(.NUM_DOM(NUM_DOM), .NBANK(NBANK), .SET_WINS(SET_WINS)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (trans_v & {NUM_DOM{seq_done}}),
      .en_we   (en_we),
      .msk_we  (msk_we),
      .clr_we  (clr_we),
      .wdata   (bus_wdata),
      .flag_q  (flag_q),
      .en_q    (en_q),
      .msk_q   (msk_q),
      .irq     (irq)
   );

   // read path
   logic [PADW-1:0] on_pad, off_pad, flg_pad, ena_pad, msk_pad;
   logic [31:0]     rd_d;
   int              sb_i, wb_i;

   assign on_pad  = PADW'(on_v);
   assign off_pad = PADW'(off_v);
   assign flg_pad = PADW'(flag_q);
   assign ena_pad = PADW'(en_q);
   assign msk_pad = PADW'(msk_q);
   assign sb_i    = sum_bank_ok ? int'(bus_addr[2]) : 0;
   assign wb_i    = wbank_ok ? int'(wbank) : 0;

   always_comb begin
      rd_d = '0;
      if (glb_hit) begin
         rd_d[1:0] = {2{~busy}};
      end else if (cm_hit) begin
         case (grp)
            GRP_SUM: if (sum_bank_ok)
                        rd_d = bus_addr[3] ? off_pad[sb_i*32 +: 32] : on_pad[sb_i*32 +: 32];
            GRP_FLG: if (wbank_ok) rd_d = flg_pad[wb_i*32 +: 32];
            GRP_ENA: if (wbank_ok) rd_d = ena_pad[wb_i*32 +: 32];
            default: if (wbank_ok) rd_d = msk_pad[wb_i*32 +: 32];
         endcase
      end else if (dom_hit) begin
         if (dsub == SUB_STAT)     rd_d = pd_status_word(st[dom_sel]);
         else if (dsub == SUB_ERR) rd_d[0] = err_v[dom_sel];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata  <= '0;
         bus_rvalid <= 1'b0;
      end else begin
         bus_rvalid <= rd_en;
         if (rd_en) bus_rdata <= rd_d;
      end
   end

   assert_single_transit_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(trans_v));
   assert_busy_covers_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (|trans_v) |-> busy);
   assert_rvalid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> bus_rvalid);

endmodule

// File: tb/sim_pdom_regblock.sv
`timescale 1ns/1ps
module sim_pdom_regblock;
   localparam int ND  = 40;
   localparam int DLY = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 1'b0;
   logic        wr = 1'b0;
   logic [15:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        rvalid, irq;

   always #4 clk = ~clk;

   pdom_regblock #(.NUM_DOM(ND), .SEQ_DELAY(DLY), .ADDR_W(16)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
      .bus_wdata(wdata), .bus_rdata(rdata), .bus_rvalid(rvalid), .irq(irq)
   );

   logic [15:0] qa [$];
   logic [31:0] qe [$];
   string       qt [$];
   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   function automatic logic [15:0] dblk(input int n);
      return 16'(32'h1000 + n * 32'h40);
   endfunction

   task automatic rd(input logic [15:0] a, input logic [31:0] e, input string tag);
      sel = 1'b1; wr = 1'b0; addr = a;
      qa.push_back(a); qe.push_back(e); qt.push_back(tag);
      @(negedge clk);
      sel = 1'b0;
   endtask

   task automatic wreg(input logic [15:0] a, input logic [31:0] d);
      sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      sel = 1'b0; wr = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk_irq(input logic e, input string tag);
      n_chk++;
      if (irq !== e) begin
         n_bad++;
         $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, e);
      end
   endtask

   // monitor: scoreboard compare
   always @(negedge clk) begin
      logic [31:0] e;
      logic [15:0] a;
      string t;
      if (rst_n && rvalid) begin
         n_chk++;
         if (qe.size() == 0) begin
            n_bad++;
            $display("FAIL R9 unexpected read actual=%h expected=none", rdata);
         end else begin
            e = qe.pop_front(); a = qa.pop_front(); t = qt.pop_front();
            if (rdata !== e) begin
               n_bad++;
               $display("FAIL %s addr=%h actual=%h expected=%h", t, a, rdata, e);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk_irq(1'b0, "R1 reset irq");
      rd(16'h0000, 32'h3, "R1 ready after reset");
      rd(dblk(0), 32'h1, "R1 dom0 off");
      rd(dblk(ND-1), 32'h1, "R1 last dom off");
      rd(dblk(0) + 16'hC, 32'h0, "R1 err clear");
      rd(16'h0810, 32'h0, "R1 flags clear");
      rd(16'h0808, 32'hFFFF_FFFF, "R6 off bank0");
      rd(16'h080C, 32'h0000_00FF, "R6 off bank1");
      rd(16'h0800, 32'h0, "R6 on bank0");

      wreg(16'h0820, 32'h8);
      rd(16'h0820, 32'h8, "R7 enable readback");

      // R3 on-sequence of dom3 with R4 rejection of dom5 inside the window
      wreg(dblk(3) + 16'h4, 32'h1);                      // cycle k
      rd(dblk(3), 32'h1000, "R3 dom3 rising");           // k+1
      rd(16'h0000, 32'h0, "R2 busy during transition");  // k+2
      wreg(dblk(5) + 16'h4, 32'h1);                      // k+3 refused
      rd(dblk(5) + 16'hC, 32'h1, "R4 err set on refusal");// k+4
      rd(dblk(5), 32'h1, "R4 refused dom unchanged");    // k+5
      rd(dblk(3), 32'h1000, "R3 still rising at last cycle"); // k+6
      rd(dblk(3), 32'h10, "R3 dom3 on");                 // k+7
      rd(16'h0810, 32'h8, "R7 flag set with enable");
      chk_irq(1'b1, "R8 irq raised");
      rd(16'h0800, 32'h8, "R6 on bank0 bit3");
      rd(16'h0000, 32'h3, "R2 ready again");

      // R8 mask
      wreg(16'h0830, 32'h8);
      chk_irq(1'b0, "R8 mask lowers irq");
      rd(16'h0810, 32'h8, "R8 masked flag visible");
      // R7 write-one-to-clear
      wreg(16'h0810, 32'h0);
      rd(16'h0810, 32'h8, "R7 zero write keeps flag");
      wreg(16'h0810, 32'h8);
      rd(16'h0810, 32'h0, "R7 one write clears flag");

      // R4 resubmit accepted, R7 no flag without enable
      wreg(dblk(5) + 16'h4, 32'h1);
      rd(dblk(5) + 16'hC, 32'h0, "R4 accept clears err");
      idle(DLY + 1);
      rd(dblk(5), 32'h10, "R3 dom5 on");
      rd(16'h0810, 32'h0, "R7 no flag when disabled");

      // R5 request word with bit0 clear
      wreg(dblk(5) + 16'h8, 32'h2);
      rd(16'h0000, 32'h3, "R5 no sequence started");
      rd(dblk(5), 32'h10, "R5 dom5 still on");

      // R3 off-sequence
      wreg(dblk(3) + 16'h8, 32'h1);
      rd(dblk(3), 32'h100, "R3 dom3 falling");
      idle(DLY);
      rd(dblk(3), 32'h1, "R3 dom3 off");
      rd(16'h0810, 32'h8, "R7 flag on off completion");
      rd(16'h0808, 32'hFFFF_FFDF, "R6 off bank0 without dom5");
      chk_irq(1'b0, "R8 bank0 still masked");

      // bank 1 via dom35
      wreg(16'h0824, 32'h8);
      wreg(dblk(35) + 16'h4, 32'h1);
      idle(DLY + 1);
      rd(16'h0814, 32'h8, "R7 bank1 flag");
      rd(16'h0804, 32'h8, "R6 on bank1");
      rd(16'h080C, 32'h0000_00F7, "R6 off bank1");
      chk_irq(1'b1, "R8 bank1 unmasked irq");
      wreg(16'h0814, 32'h8);
      chk_irq(1'b0, "R8 irq after bank1 clear");

      // R9 unmapped
      rd(16'h0004, 32'h0, "R9 hole read");
      wreg(16'h0818, 32'hFFFF_FFFF);
      rd(16'h0818, 32'h0, "R9 absent bank");
      rd(dblk(ND), 32'h0, "R9 absent domain read");
      wreg(dblk(ND) + 16'h4, 32'h1);
      rd(16'h0000, 32'h3, "R9 absent domain write ignored");
      rd(dblk(0) + 16'h10, 32'h0, "R9 unused block offset");
      rd(dblk(3) + 16'h2, 32'h0, "R9 unaligned");
      rd(dblk(3), 32'h1, "R10 dom3 untouched");

      idle(3);
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule